// File: doc/BRIEF.md
# Page Request Controller

This block is the device-side engine that governs how many page requests a function may have in flight. An internal request source offers a request tagged with a group index. The block grants it only when software has switched the engine on, the engine is not draining an earlier session, fewer requests are outstanding than software has allocated, and that group index has no request already in flight. Responses come back tagged with the same group index. A response to an outstanding group retires that group. A response to a group with nothing in flight is flagged as unexpected. A response carrying a failure indication is flagged as a failure.

Software sees four word-wide registers through a simple write-enable/address/data port with a combinational read path. The registers are a control word, a status word, a read-only capacity word and an allocation word. The stopped indication means exactly "switched off and nothing in flight", and it always reads as zero while the engine is on. A self-clearing flush command discards all in-flight tracking, but only while the engine is off. If the engine is switched on while requests from an earlier session are still outstanding, it withholds new grants until those requests have drained.

Top module: `preq_engine`

## Requirements
- R1: After reset the engine is off, the allocation is 0, both flags are clear, nothing is outstanding, stopped reads 1, and no request is granted.
- R2: Register map at `reg_addr`: 0 = control (bit 0 on, bit 1 flush, which always reads 0); 1 = status (bit 0 failure flag, bit 1 unexpected-group flag, bit 2 stopped); 2 = capacity; 3 = allocation. A write of the allocation above MAX_OUT stores MAX_OUT.
- R3: `req_grant` is high in the same cycle as `req_valid` only when the engine is on, not draining, the outstanding count is below the allocation, and the offered group is not already outstanding. Each grant adds one to the outstanding count.
- R4: With the outstanding count equal to the allocation, no request is granted. Exactly `allocation` back-to-back requests on distinct groups are granted.
- R5: A response to an outstanding group retires it, whether the engine is on or off. The next cycle the outstanding count drops by one and the group may be granted again.
- R6: A response to a group that is not outstanding sets the unexpected-group flag (status bit 1) and leaves the outstanding count unchanged.
- R7: Any response with `rsp_fail` high sets the failure flag (status bit 0). Writing 1 to a flag bit of the status word clears that flag. A set in the same cycle wins over the clear.
- R8: Stopped (status bit 2) reads 1 exactly when the engine is off and nothing is outstanding. It reads 0 whenever the engine is on.
- R9: Writing 0 to the on bit stops grants from the next cycle, whatever the bit held before.
- R10: Writing the flush bit while the engine is off clears all outstanding groups and the count, which makes the engine stopped. While the engine is on, the flush bit is ignored.
- R11: If the engine is switched on while requests are outstanding, no grant is issued until the count reaches zero. Grants resume one cycle after the count reaches zero.
- R12: The capacity register reads MAX_OUT, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| req_valid | input | 1 | Internal source offers a page request |
| req_grp | input | GRP_W | Group index of the offered request |
| req_grant | output | 1 | Request accepted this cycle |
| rsp_valid | input | 1 | A page response arrives |
| rsp_grp | input | GRP_W | Group index of the response |
| rsp_fail | input | 1 | Response reports failure |

## Verification
A wrong outstanding count or group bitmap shows up at the ports in the cycle after the faulty update. It appears as a grant where the model expects a stall (or the reverse), as a stopped bit that rises too early or too late, or as an unexpected-group flag on a response that should have retired. Because the bench compares `req_grant` and `reg_rdata` on every clock, such an error is caught at the first cycle in which the state feeds the grant decision or the addressed register. A drain hold that is never set or never released appears directly as a grant mismatch in the re-enable sequence.

// File: rtl/preq_pkg.sv
package preq_pkg;
    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_MAX   = 2'd2,
        A_ALLOC = 2'd3
    } preq_addr_e;

    localparam int CTL_ON_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int ST_FAIL_BIT   = 0;
    localparam int ST_UNEXP_BIT  = 1;
    localparam int ST_STOP_BIT   = 2;
endpackage

// File: rtl/preq_tracker.sv
module preq_tracker #(
    parameter int GRP_W = 5,
    parameter int CNT_W = 6,
    localparam int NGRP = 1 << GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [GRP_W-1:0] issue_grp,
    input  logic             rsp_valid,
    input  logic [GRP_W-1:0] rsp_grp,
    input  logic             flush,
    output logic [NGRP-1:0]  busy,
    output logic [CNT_W-1:0] cnt,
    output logic             rsp_miss
);
    typedef struct packed {
        logic [NGRP-1:0]  busy;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rsp_hit;

    always_comb begin
        trk_d    = trk_q;
        rsp_hit  = rsp_valid && trk_q.busy[rsp_grp];
        rsp_miss = rsp_valid && !trk_q.busy[rsp_grp];
        if (flush) begin
            trk_d.busy = '0;
            trk_d.cnt  = '0;
        end else begin
            if (issue)   trk_d.busy[issue_grp] = 1'b1;
            if (rsp_hit) trk_d.busy[rsp_grp]   = 1'b0;
            trk_d.cnt = trk_q.cnt + CNT_W'(issue) - CNT_W'(rsp_hit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign busy = trk_q.busy;
    assign cnt  = trk_q.cnt;

    // R5
    cnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.cnt == CNT_W'($countones(trk_q.busy)));

    // R6
    miss_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss && !issue && !flush) |=> (trk_q.cnt == $past(trk_q.cnt)));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (trk_q.cnt == '0 && trk_q.busy == '0));
endmodule

// File: rtl/preq_regs.sv
module preq_regs
    import preq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 6,
    parameter int MAX_OUT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rsp_valid,
    input  logic              rsp_fail,
    input  logic              rsp_miss,
    input  logic [CNT_W-1:0]  cnt,
    output logic              on,
    output logic              hold,
    output logic [CNT_W-1:0]  alloc,
    output logic              flush
);
    typedef struct packed {
        logic             on;
        logic             hold;
        logic             fail;
        logic             unexp;
        logic [CNT_W-1:0] alloc;
    } rst_t;

    rst_t st_d, st_q;
    preq_addr_e sel;
    logic wr_ctrl, wr_stat, wr_alloc, stopped;

    always_comb begin
        sel      = preq_addr_e'(addr);
        wr_ctrl  = wr_en && (sel == A_CTRL);
        wr_stat  = wr_en && (sel == A_STAT);
        wr_alloc = wr_en && (sel == A_ALLOC);
        stopped  = !st_q.on && (cnt == '0);
        st_d     = st_q;

        if (wr_ctrl) st_d.on = wdata[CTL_ON_BIT];
        flush = wr_ctrl && wdata[CTL_FLUSH_BIT] && !st_q.on;

        if (!st_d.on)
            st_d.hold = 1'b0;
        else if (!st_q.on)
            st_d.hold = (cnt != '0);
        else
            st_d.hold = st_q.hold && (cnt != '0);

        if (wr_stat && wdata[ST_FAIL_BIT])  st_d.fail  = 1'b0;
        if (wr_stat && wdata[ST_UNEXP_BIT]) st_d.unexp = 1'b0;
        if (rsp_valid && rsp_fail)          st_d.fail  = 1'b1;
        if (rsp_miss)                       st_d.unexp = 1'b1;

        if (wr_alloc) begin
            if (wdata > DATA_W'(MAX_OUT)) st_d.alloc = CNT_W'(MAX_OUT);
            else                          st_d.alloc = wdata[CNT_W-1:0];
        end

        rdata = '0;
        unique case (sel)
            A_CTRL:  rdata[CTL_ON_BIT] = st_q.on;
            A_STAT: begin
                rdata[ST_FAIL_BIT]  = st_q.fail;
                rdata[ST_UNEXP_BIT] = st_q.unexp;
                rdata[ST_STOP_BIT]  = stopped;
            end
            A_MAX:   rdata = DATA_W'(MAX_OUT);
            A_ALLOC: rdata = DATA_W'(st_q.alloc);
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on    = st_q.on;
    assign hold  = st_q.hold;
    assign alloc = st_q.alloc;

    // R8
    stop_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == A_STAT && st_q.on) |-> !rdata[ST_STOP_BIT]);

    // R7
    fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fail) |=> st_q.fail);

    // R2
    alloc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.alloc <= CNT_W'(MAX_OUT));
endmodule

// File: rtl/preq_gate.sv
module preq_gate #(
    parameter int GRP_W = 5,
    parameter int CNT_W = 6,
    localparam int NGRP = 1 << GRP_W
) (
    input  logic             req_valid,
    input  logic [GRP_W-1:0] req_grp,
    input  logic             on,
    input  logic             hold,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] alloc,
    input  logic [NGRP-1:0]  busy,
    output logic             grant
);
    logic room, grp_free;

    always_comb begin
        room     = (cnt < alloc);
        grp_free = !busy[req_grp];
        grant    = req_valid && on && !hold && room && grp_free;
    end
endmodule

// File: rtl/preq_engine.sv
module preq_engine #(
    parameter int DATA_W  = 32,
    parameter int GRP_W   = 5,
    parameter int MAX_OUT = 32,
    localparam int CNT_W  = $clog2(MAX_OUT + 1),
    localparam int NGRP   = 1 << GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_valid,
    input  logic [GRP_W-1:0]  req_grp,
    output logic              req_grant,
    input  logic              rsp_valid,
    input  logic [GRP_W-1:0]  rsp_grp,
    input  logic              rsp_fail
);
    logic             on, hold, flush, rsp_miss;
    logic [CNT_W-1:0] cnt, alloc;
    logic [NGRP-1:0]  busy;

    preq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .rsp_valid(rsp_valid),
        .rsp_fail(rsp_fail), .rsp_miss(rsp_miss), .cnt(cnt), .on(on),
        .hold(hold), .alloc(alloc), .flush(flush)
    );

    preq_gate #(.GRP_W(GRP_W), .CNT_W(CNT_W)) u_gate (
        .req_valid(req_valid), .req_grp(req_grp), .on(on), .hold(hold),
        .cnt(cnt), .alloc(alloc), .busy(busy), .grant(req_grant)
    );

    preq_tracker #(.GRP_W(GRP_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .issue(req_grant), .issue_grp(req_grp),
        .rsp_valid(rsp_valid), .rsp_grp(rsp_grp), .flush(flush),
        .busy(busy), .cnt(cnt), .rsp_miss(rsp_miss)
    );

    // R4
    alloc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> (cnt < alloc));

    // R9
    grant_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> on);

    // R11
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !req_grant);

    // R3
    grant_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && !rsp_valid) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: tb/sim_preq_engine.sv
`timescale 1ns/1ps
module sim_preq_engine;
    localparam int MAXO = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rv = 1'b0;
    logic [4:0]  rg = '0;
    logic        grant;
    logic        sv = 1'b0;
    logic [4:0]  sg = '0;
    logic        sf = 1'b0;

    always #2 clk = ~clk;

    preq_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .req_valid(rv), .req_grp(rg),
        .req_grant(grant), .rsp_valid(sv), .rsp_grp(sg), .rsp_fail(sf)
    );

    bit          m_on, m_hold, m_fail, m_unexp;
    int          m_alloc, m_cnt;
    bit [31:0]   m_busy;
    int          vec, bad, grants;
    logic [31:0] last_rd;
    logic        last_gr;
    string       tag = "R1";
    bit          done;

    task automatic chk(string t, int got, int exp);
        vec++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    task automatic tick();
        bit e_gr, hit, miss, flush, n_on, n_hold, n_fail, n_unexp;
        int n_cnt, n_alloc;
        bit [31:0] n_busy;
        logic [31:0] e_rd;
        #1;
        e_gr = rv && m_on && !m_hold && (m_cnt < m_alloc) && !m_busy[rg];
        case (addr)
            2'd0: e_rd = {31'b0, m_on};
            2'd1: e_rd = {29'b0, (!m_on && m_cnt == 0), m_unexp, m_fail};
            2'd2: e_rd = 32'(MAXO);
            default: e_rd = 32'(m_alloc);
        endcase
        vec++;
        if (grant !== e_gr || rdata !== e_rd) begin
            bad++;
            $display("FAIL %s: grant=%0b rdata=%h expected grant=%0b rdata=%h",
                     tag, grant, rdata, e_gr, e_rd);
        end
        last_rd = rdata;
        last_gr = grant;
        if (grant) grants++;
        hit   = sv && m_busy[sg];
        miss  = sv && !m_busy[sg];
        flush = we && addr == 2'd0 && wdata[1] && !m_on;
        n_on  = (we && addr == 2'd0) ? wdata[0] : m_on;
        if (!n_on) n_hold = 0;
        else if (!m_on) n_hold = (m_cnt != 0);
        else n_hold = m_hold && (m_cnt != 0);
        n_busy = m_busy;
        n_cnt  = m_cnt;
        if (flush) begin
            n_busy = '0;
            n_cnt = 0;
        end else begin
            if (e_gr) begin n_busy[rg] = 1'b1; n_cnt++; end
            if (hit)  begin n_busy[sg] = 1'b0; n_cnt--; end
        end
        n_fail  = m_fail;
        n_unexp = m_unexp;
        if (we && addr == 2'd1 && wdata[0]) n_fail = 0;
        if (we && addr == 2'd1 && wdata[1]) n_unexp = 0;
        if (sv && sf) n_fail = 1;
        if (miss) n_unexp = 1;
        n_alloc = m_alloc;
        if (we && addr == 2'd3) n_alloc = (wdata > 32'(MAXO)) ? MAXO : int'(wdata);
        @(posedge clk);
        m_on = n_on; m_hold = n_hold; m_busy = n_busy; m_cnt = n_cnt;
        m_fail = n_fail; m_unexp = n_unexp; m_alloc = n_alloc;
        @(negedge clk);
    endtask

    task automatic idle();
        we = 0; rv = 0; sv = 0; sf = 0; addr = 2'd0; wdata = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        we = 1; addr = a; wdata = d; tick(); idle();
    endtask

    task automatic rd(input logic [1:0] a);
        addr = a; tick(); idle();
    endtask

    task automatic req(input logic [4:0] g);
        rv = 1; rg = g; tick(); idle();
    endtask

    task automatic rsp(input logic [4:0] g, input logic f);
        sv = 1; sg = g; sf = f; tick(); idle();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        tag = "R1";
        rd(2'd0); chk("R1 control", int'(last_rd), 0);
        rd(2'd1); chk("R1 status stopped", int'(last_rd), 4);
        rd(2'd3); chk("R1 alloc", int'(last_rd), 0);
        rv = 1; rg = 5'd3; tick(); idle(); chk("R1 no grant", int'(last_gr), 0);

        // R2 register map and clamp, R12 capacity read-only
        tag = "R2";
        wr(2'd3, 32'd40); rd(2'd3); chk("R2 alloc clamp", int'(last_rd), MAXO);
        wr(2'd3, 32'd4);  rd(2'd3); chk("R2 alloc", int'(last_rd), 4);
        wr(2'd0, 32'd2);  rd(2'd0); chk("R2 flush reads 0", int'(last_rd), 0);
        tag = "R12";
        wr(2'd2, 32'd7);  rd(2'd2); chk("R12 capacity", int'(last_rd), MAXO);

        // R3 / R4 issue and stall at allocation
        tag = "R4";
        wr(2'd0, 32'd1);
        grants = 0;
        for (int g = 0; g < 6; g++) req(5'(g));
        chk("R4 grants at limit", grants, 4);
        rd(2'd1); chk("R8 stopped hidden while on", int'(last_rd[2]), 0);

        // R5 retire, R3 busy group blocked
        tag = "R5";
        rsp(5'd1, 1'b0);
        req(5'd0); chk("R3 busy group refused", int'(last_gr), 0);
        req(5'd6); chk("R5 grant after retire", int'(last_gr), 1);

        // R6 unexpected group
        tag = "R6";
        rsp(5'd1, 1'b0); rd(2'd1); chk("R6 unexpected flag", int'(last_rd), 2);

        // R7 failure flag and W1C
        tag = "R7";
        rsp(5'd2, 1'b1); rd(2'd1); chk("R7 fail flag", int'(last_rd), 3);
        wr(2'd1, 32'd1); rd(2'd1); chk("R7 clear fail", int'(last_rd), 2);
        wr(2'd1, 32'd2); rd(2'd1); chk("R7 clear unexp", int'(last_rd), 0);
        we = 1; addr = 2'd1; wdata = 32'd3; sv = 1; sg = 5'd2; sf = 1; tick(); idle();
        rd(2'd1); chk("R7 set wins over clear", int'(last_rd), 3);
        wr(2'd1, 32'd3);

        // R9 disable stops grants, R8 stopped after drain
        tag = "R9";
        wr(2'd0, 32'd0);
        req(5'd7); chk("R9 no grant while off", int'(last_gr), 0);
        tag = "R8";
        rd(2'd1); chk("R8 not stopped while pending", int'(last_rd[2]), 0);
        rsp(5'd0, 1'b0); rsp(5'd3, 1'b0);
        rd(2'd1); chk("R8 still pending", int'(last_rd[2]), 0);
        rsp(5'd6, 1'b0);
        rd(2'd1); chk("R8 stopped after last response", int'(last_rd[2]), 1);

        // R10 flush ignored while on, effective while off
        tag = "R10";
        wr(2'd0, 32'd1);
        req(5'd8); req(5'd9);
        wr(2'd0, 32'd3);
        wr(2'd0, 32'd0);
        rd(2'd1); chk("R10 flush ignored while on", int'(last_rd[2]), 0);
        wr(2'd0, 32'd2);
        rd(2'd1); chk("R10 flush makes stopped", int'(last_rd[2]), 1);
        rsp(5'd8, 1'b0);
        rd(2'd1); chk("R10 flushed group unexpected", int'(last_rd[1]), 1);
        wr(2'd1, 32'd2);

        // R11 re-enable with outstanding requests waits for drain
        tag = "R11";
        wr(2'd0, 32'd1);
        req(5'd10); req(5'd11);
        wr(2'd0, 32'd0);
        wr(2'd0, 32'd1);
        req(5'd12); chk("R11 held while draining", int'(last_gr), 0);
        rsp(5'd10, 1'b0);
        req(5'd12); chk("R11 still held", int'(last_gr), 0);
        rsp(5'd11, 1'b0);
        tick();
        req(5'd12); chk("R11 grant after drain", int'(last_gr), 1);

        // R3 mixed traffic compared each cycle
        tag = "R3";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            rv = ($urandom_range(0, 1) == 1);
            rg = 5'($urandom_range(0, 15));
            sv = ($urandom_range(0, 2) == 0);
            sg = 5'($urandom_range(0, 15));
            sf = ($urandom_range(0, 9) == 0);
            addr = 2'($urandom_range(0, 3));
            we = (r < 8);
            if (addr == 2'd0) wdata = (r < 6) ? 32'd1 : 32'($urandom_range(0, 3));
            else wdata = 32'($urandom_range(0, 40));
            tick();
        end
        idle();
        tick();

        done = 1;
        summary();
        $finish;
    end
endmodule